// File: doc/BRIEF.md
# Receive-side PTP Event Frame Classifier

This block looks at the already-parsed header fields of each incoming frame and decides whether that frame should have its arrival time captured. A header parser upstream presents the frame's EtherType, a flag that says the frame carries UDP, the UDP destination port, the PTP version nibble and the PTP message-type nibble. It presents them together with a one-cycle `hdr_valid` pulse. The classifier registers its decision and raises `ts_req` for one cycle. That strobe drives the capture latch.

Software picks one of three behaviours through a two-bit mode field:
- **Stamping off.**
- **Version 1 over UDP.** Only one chosen message type is stamped.
- **Version 2 event stamping.** Every event message is stamped, on either Layer 2 or UDP transport.

A 32-bit selector register carries two values. Its upper half is the PTP event UDP port, normally 319. Its lowest four bits are the version 1 message type to match. A separate EtherType filter, made of an enable, a timestamp bit and a 16-bit type, decides whether Layer 2 frames can qualify.

Top module: `ptp_rx_event_classifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ts_req` is 0 on the next cycle, whatever the header and configuration inputs are.
- R2: With `cfg_mode` = 2'b00 (off), no frame raises `ts_req`.
- R3: With `cfg_mode` = 2'b01 (version 1 over UDP), a frame is stamped when all of the following hold:
  - `hdr_is_udp` = 1;
  - `hdr_udp_dport` equals `cfg_msgsel[31:16]`;
  - `hdr_ptp_ver` = 1;
  - `hdr_msg_type` equals `cfg_msgsel[3:0]`.
- R4: In version 1 mode only the selected type is stamped. With Sync (0) selected, a Delay_Req (1) frame is not stamped. With Delay_Req selected, a Sync frame is not stamped.
- R5: In version 1 mode, a frame is not stamped if it is not UDP, if its port differs from the configured port, or if its version is not 1.
- R6: With `cfg_mode` = 2'b10 (version 2 event), a version 2 UDP frame on the configured port is stamped when its message type has bit 3 clear. This covers Sync 0, Delay_Req 1, Pdelay_Req 2 and Pdelay_Resp 3.
- R7: In version 2 mode, message types with bit 3 set (general messages such as Follow_Up 8 and Announce 11) are never stamped.
- R8: In version 2 mode, a non-UDP (Layer 2) event frame is stamped only when all of the following hold:
  - `cfg_etf_en` = 1;
  - `cfg_etf_ts` = 1;
  - `cfg_etf_type` = 16'h88F7;
  - `hdr_ethertype` = 16'h88F7.
- R9: In version 2 mode, a frame whose version field is not 2 is not stamped.
- R10: `ts_req` rises exactly one cycle after a qualifying `hdr_valid` and lasts one cycle per frame. Back-to-back frames give one pulse each. With `hdr_valid` low, `ts_req` is 0 on the next cycle.
- R11: `cfg_mode` = 2'b11 is reserved and behaves as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 00 off, 01 version 1 UDP, 10 version 2 event, 11 reserved |
| cfg_msgsel | input | 32 | [31:16] event UDP port, [3:0] version 1 message type |
| cfg_etf_en | input | 1 | EtherType filter enable |
| cfg_etf_ts | input | 1 | EtherType filter timestamp permission |
| cfg_etf_type | input | 16 | EtherType filter value |
| hdr_valid | input | 1 | One-cycle pulse, header fields valid |
| hdr_ethertype | input | 16 | Frame EtherType |
| hdr_is_udp | input | 1 | Frame carries UDP |
| hdr_udp_dport | input | 16 | UDP destination port |
| hdr_ptp_ver | input | 4 | PTP version field |
| hdr_msg_type | input | 4 | PTP message type field |
| ts_req | output | 1 | Registered timestamp request strobe |

## Verification
The case hardest to reach is a Layer 2 frame in version 2 mode. Stamping it depends on three filter settings and the frame's EtherType all lining up at once, and each of them can veto the others. The stimulus steps through the four single-fault variants one at a time: filter disabled, timestamp bit clear, a foreign filter type with a matching frame type, and a UDP port mismatch. Each variant sits between passing Layer 2 frames. Back-to-back frames of mixed verdicts, and idle cycles whose fields still match, show that the strobe follows the frame pulse and not the field values.

// File: rtl/ptpcls_pkg.sv
// Shared types and constants for the receive PTP event classifier.
// Assumes fixed IEEE 1588 field widths; widths are still exported as
// localparams so submodules stay parameterised.
package ptpcls_pkg;
    localparam int PORT_W  = 16;
    localparam int ETYPE_W = 16;
    localparam int VER_W   = 4;
    localparam int MSG_W   = 4;
    localparam int SEL_W   = 32;

    localparam logic [ETYPE_W-1:0] ETYPE_1588 = 16'h88F7;

    typedef enum logic [1:0] {
        PCM_OFF    = 2'b00,
        PCM_V1_L4  = 2'b01,
        PCM_V2_EVT = 2'b10,
        PCM_RSVD   = 2'b11
    } ptpcls_mode_e;
endpackage

// File: rtl/ptpcls_cfg_split.sv
// Splits the combined selector register into the event UDP port (upper
// bits) and the version 1 message type to match (lowest bits).
// Assumes SEL_W >= PORT_W + MSG_W.
module ptpcls_cfg_split #(
    parameter int SEL_W  = ptpcls_pkg::SEL_W,
    parameter int PORT_W = ptpcls_pkg::PORT_W,
    parameter int MSG_W  = ptpcls_pkg::MSG_W
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [PORT_W-1:0] evt_port,
    output logic [MSG_W-1:0]  v1_type
);
    localparam int PORT_LSB = SEL_W - PORT_W;

    // Field extraction.
    always_comb begin
        evt_port = sel[SEL_W-1:PORT_LSB];
        v1_type  = sel[MSG_W-1:0];
    end
endmodule

// File: rtl/ptpcls_transport.sv
// Decides whether the frame's transport is eligible: UDP on the event
// port, or Layer 2 through an EtherType filter that is enabled, allows
// timestamping and carries the 1588 EtherType. Purely combinational.
module ptpcls_transport #(
    parameter int PORT_W  = ptpcls_pkg::PORT_W,
    parameter int ETYPE_W = ptpcls_pkg::ETYPE_W
) (
    input  logic               is_udp,
    input  logic [PORT_W-1:0]  dport,
    input  logic [ETYPE_W-1:0] ethertype,
    input  logic [PORT_W-1:0]  evt_port,
    input  logic               etf_en,
    input  logic               etf_ts,
    input  logic [ETYPE_W-1:0] etf_type,
    output logic               l4_hit,
    output logic               l2_hit
);
    logic filt_armed;

    // Filter is usable only when enabled, stamping, and set to 1588.
    always_comb begin
        filt_armed = etf_en && etf_ts && (etf_type == ptpcls_pkg::ETYPE_1588);
    end

    // Per-transport eligibility.
    always_comb begin
        l4_hit = is_udp && (dport == evt_port);
        l2_hit = !is_udp && filt_armed && (ethertype == etf_type);
    end
endmodule

// File: rtl/ptpcls_msg_decide.sv
// Applies the mode rules to the version and message-type fields and the
// transport verdicts. Event codes are those below EVT_LIMIT; the lookup
// mask is built by a generate loop over all message codes.
module ptpcls_msg_decide #(
    parameter int VER_W     = ptpcls_pkg::VER_W,
    parameter int MSG_W     = ptpcls_pkg::MSG_W,
    parameter int EVT_LIMIT = 8
) (
    input  logic [1:0]       mode,
    input  logic [VER_W-1:0] ver,
    input  logic [MSG_W-1:0] msg,
    input  logic [MSG_W-1:0] v1_type,
    input  logic             l4_hit,
    input  logic             l2_hit,
    output logic             hit
);
    import ptpcls_pkg::*;
    localparam int NCODES = 1 << MSG_W;

    logic [NCODES-1:0] evt_mask;

    for (genvar c = 0; c < NCODES; c++) begin : g_evt
        assign evt_mask[c] = (c < EVT_LIMIT);
    end

    logic v1_ok, v2_ok;

    // Per-mode match terms.
    always_comb begin
        v1_ok = l4_hit && (ver == VER_W'(1)) && (msg == v1_type);
        v2_ok = (l4_hit || l2_hit) && (ver == VER_W'(2)) && evt_mask[msg];
    end

    // Mode selection; off and reserved stamp nothing.
    always_comb begin
        unique case (ptpcls_mode_e'(mode))
            PCM_V1_L4:  hit = v1_ok;
            PCM_V2_EVT: hit = v2_ok;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptp_rx_event_classifier.sv
// Top of the receive PTP event classifier. Takes parsed header fields with
// a one-cycle valid pulse and issues a registered one-cycle timestamp
// request the cycle after. Assumes configuration is stable around frames.
module ptp_rx_event_classifier #(
    parameter int SEL_W   = ptpcls_pkg::SEL_W,
    parameter int PORT_W  = ptpcls_pkg::PORT_W,
    parameter int ETYPE_W = ptpcls_pkg::ETYPE_W,
    parameter int VER_W   = ptpcls_pkg::VER_W,
    parameter int MSG_W   = ptpcls_pkg::MSG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [SEL_W-1:0]   cfg_msgsel,
    input  logic               cfg_etf_en,
    input  logic               cfg_etf_ts,
    input  logic [ETYPE_W-1:0] cfg_etf_type,
    input  logic               hdr_valid,
    input  logic [ETYPE_W-1:0] hdr_ethertype,
    input  logic               hdr_is_udp,
    input  logic [PORT_W-1:0]  hdr_udp_dport,
    input  logic [VER_W-1:0]   hdr_ptp_ver,
    input  logic [MSG_W-1:0]   hdr_msg_type,
    output logic               ts_req
);
    logic [PORT_W-1:0] evt_port;
    logic [MSG_W-1:0]  v1_type;
    logic              l4_hit, l2_hit, hit;

    ptpcls_cfg_split #(.SEL_W(SEL_W), .PORT_W(PORT_W), .MSG_W(MSG_W)) u_split (
        .sel(cfg_msgsel), .evt_port(evt_port), .v1_type(v1_type)
    );

    ptpcls_transport #(.PORT_W(PORT_W), .ETYPE_W(ETYPE_W)) u_tx (
        .is_udp(hdr_is_udp), .dport(hdr_udp_dport), .ethertype(hdr_ethertype),
        .evt_port(evt_port), .etf_en(cfg_etf_en), .etf_ts(cfg_etf_ts),
        .etf_type(cfg_etf_type), .l4_hit(l4_hit), .l2_hit(l2_hit)
    );

    ptpcls_msg_decide #(.VER_W(VER_W), .MSG_W(MSG_W)) u_dec (
        .mode(cfg_mode), .ver(hdr_ptp_ver), .msg(hdr_msg_type),
        .v1_type(v1_type), .l4_hit(l4_hit), .l2_hit(l2_hit), .hit(hit)
    );

    // Register the per-frame decision into a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_req <= 1'b0;
        else        ts_req <= hdr_valid && hit;
    end
endmodule

// File: rtl/ptpcls_checker.sv
// Port-level properties of the classifier, bound to the top module.
module ptpcls_checker #(
    parameter int SEL_W   = ptpcls_pkg::SEL_W,
    parameter int PORT_W  = ptpcls_pkg::PORT_W,
    parameter int ETYPE_W = ptpcls_pkg::ETYPE_W,
    parameter int VER_W   = ptpcls_pkg::VER_W,
    parameter int MSG_W   = ptpcls_pkg::MSG_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         cfg_mode,
    input logic [SEL_W-1:0]   cfg_msgsel,
    input logic               cfg_etf_en,
    input logic               cfg_etf_ts,
    input logic [ETYPE_W-1:0] cfg_etf_type,
    input logic               hdr_valid,
    input logic [ETYPE_W-1:0] hdr_ethertype,
    input logic               hdr_is_udp,
    input logic [PORT_W-1:0]  hdr_udp_dport,
    input logic [VER_W-1:0]   hdr_ptp_ver,
    input logic [MSG_W-1:0]   hdr_msg_type,
    input logic               ts_req
);
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_mode == 2'b00) |=> !ts_req);
    a_r11_rsvd_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_mode == 2'b11) |=> !ts_req);
    a_r10_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !ts_req);
    a_r5_v1_udp_only: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_mode == 2'b01 && !hdr_is_udp) |=> !ts_req);
    a_r7_general_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_mode == 2'b10 && hdr_msg_type[MSG_W-1]) |=> !ts_req);
    a_r9_v2_version: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_mode == 2'b10 && hdr_ptp_ver != VER_W'(2)) |=> !ts_req);
    a_r8_l2_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_is_udp && !(cfg_etf_en && cfg_etf_ts)) |=> !ts_req);
    a_r3_v1_type: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && cfg_mode == 2'b01 && hdr_msg_type != cfg_msgsel[MSG_W-1:0]) |=> !ts_req);
endmodule

bind ptp_rx_event_classifier ptpcls_checker #(
    .SEL_W(SEL_W), .PORT_W(PORT_W), .ETYPE_W(ETYPE_W), .VER_W(VER_W), .MSG_W(MSG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_msgsel(cfg_msgsel),
    .cfg_etf_en(cfg_etf_en), .cfg_etf_ts(cfg_etf_ts), .cfg_etf_type(cfg_etf_type),
    .hdr_valid(hdr_valid), .hdr_ethertype(hdr_ethertype), .hdr_is_udp(hdr_is_udp),
    .hdr_udp_dport(hdr_udp_dport), .hdr_ptp_ver(hdr_ptp_ver),
    .hdr_msg_type(hdr_msg_type), .ts_req(ts_req)
);

// File: tb/tb_ptp_rx_event_classifier.sv
module tb_ptp_rx_event_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [31:0] cfg_msgsel = '0;
    logic        cfg_etf_en = 1'b0;
    logic        cfg_etf_ts = 1'b0;
    logic [15:0] cfg_etf_type = '0;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_ethertype = '0;
    logic        hdr_is_udp = 1'b0;
    logic [15:0] hdr_udp_dport = '0;
    logic [3:0]  hdr_ptp_ver = '0;
    logic [3:0]  hdr_msg_type = '0;
    logic        ts_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct { bit exp; string tag; } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ptp_rx_event_classifier dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_msgsel(cfg_msgsel),
        .cfg_etf_en(cfg_etf_en), .cfg_etf_ts(cfg_etf_ts), .cfg_etf_type(cfg_etf_type),
        .hdr_valid(hdr_valid), .hdr_ethertype(hdr_ethertype), .hdr_is_udp(hdr_is_udp),
        .hdr_udp_dport(hdr_udp_dport), .hdr_ptp_ver(hdr_ptp_ver),
        .hdr_msg_type(hdr_msg_type), .ts_req(ts_req)
    );

    localparam logic [15:0] P319 = 16'd319;
    localparam logic [15:0] ET   = 16'h88F7;

    // Expected verdict from the requirements alone.
    function automatic bit model(bit v, logic [15:0] et, bit udp,
                                 logic [15:0] port, logic [3:0] ver, logic [3:0] mt);
        bit r;
        if (!v) return 1'b0;
        case (cfg_mode)
            2'b01: r = udp && port == cfg_msgsel[31:16] && ver == 4'd1
                       && mt == cfg_msgsel[3:0];
            2'b10: r = ver == 4'd2 && !mt[3] &&
                       ((udp && port == cfg_msgsel[31:16]) ||
                        (!udp && cfg_etf_en && cfg_etf_ts && cfg_etf_type == ET
                         && et == ET));
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    task automatic cmp(bit act, bit exp, string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ts_req=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic frame(bit v, logic [15:0] et, bit udp, logic [15:0] port,
                         logic [3:0] ver, logic [3:0] mt, string tag);
        item_t it;
        @(negedge clk);
        hdr_valid = v; hdr_ethertype = et; hdr_is_udp = udp;
        hdr_udp_dport = port; hdr_ptp_ver = ver; hdr_msg_type = mt;
        it.exp = model(v, et, udp, port, ver, mt);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(string tag);
        frame(1'b0, hdr_ethertype, hdr_is_udp, hdr_udp_dport, hdr_ptp_ver,
              hdr_msg_type, tag);
    endtask

    // Monitor: compare each cycle's output against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                cmp(ts_req, it.exp, it.tag);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: qualifying frames presented during reset give no strobe.
        cfg_mode = 2'b01; cfg_msgsel = {P319, 16'h0000};
        hdr_valid = 1'b1; hdr_is_udp = 1'b1; hdr_udp_dport = P319;
        hdr_ptp_ver = 4'd1; hdr_msg_type = 4'd0;
        repeat (3) begin
            @(posedge clk); #1;
            cmp(ts_req, 1'b0, "R1 reset");
        end
        @(negedge clk);
        rst_n = 1'b1; hdr_valid = 1'b0;
        cfg_mode = 2'b00; cfg_msgsel = '0;
        idle("R10 idle after reset");

        // R2: off mode.
        frame(1, 16'h0800, 1, P319, 1, 0, "R2 off v1");
        frame(1, 16'h0800, 1, P319, 2, 0, "R2 off v2");

        // R3/R4/R5: version 1, Sync selected.
        @(negedge clk); cfg_mode = 2'b01; cfg_msgsel = {P319, 16'h0000};
        idle("R10 idle");
        frame(1, 16'h0800, 1, P319, 1, 0, "R3 v1 sync");
        frame(1, 16'h0800, 1, P319, 1, 1, "R4 v1 delay_req unselected");
        frame(1, 16'h0800, 1, 16'd320, 1, 0, "R5 v1 port mismatch");
        frame(1, 16'h0800, 1, P319, 2, 0, "R5 v1 wrong version");
        frame(1, ET, 0, P319, 1, 0, "R5 v1 not udp");
        // Delay_Req selected.
        @(negedge clk); cfg_msgsel = {P319, 16'h0001};
        idle("R10 idle");
        frame(1, 16'h0800, 1, P319, 1, 1, "R4 v1 delay_req selected");
        frame(1, 16'h0800, 1, P319, 1, 0, "R4 v1 sync unselected");

        // R6-R9: version 2 event mode with armed filter.
        @(negedge clk); cfg_mode = 2'b10; cfg_msgsel = {P319, 16'h0000};
        cfg_etf_en = 1; cfg_etf_ts = 1; cfg_etf_type = ET;
        idle("R10 idle");
        for (int m = 0; m < 4; m++) frame(1, 16'h0800, 1, P319, 2, 4'(m), "R6 v2 event udp");
        frame(1, 16'h0800, 1, P319, 2, 8, "R7 follow_up");
        frame(1, 16'h0800, 1, P319, 2, 11, "R7 announce");
        frame(1, 16'h0800, 1, P319, 1, 0, "R9 v1 in v2 mode");
        frame(1, ET, 0, 16'd0, 2, 0, "R8 l2 armed");
        frame(1, ET, 0, 16'd0, 2, 3, "R8 l2 pdelay_resp");
        frame(1, 16'h0800, 1, 16'd320, 2, 0, "R6 v2 port mismatch");
        @(negedge clk); cfg_etf_ts = 0; idle("R10 idle");
        frame(1, ET, 0, 16'd0, 2, 0, "R8 ts bit clear");
        @(negedge clk); cfg_etf_ts = 1; cfg_etf_en = 0; idle("R10 idle");
        frame(1, ET, 0, 16'd0, 2, 0, "R8 filter disabled");
        @(negedge clk); cfg_etf_en = 1; cfg_etf_type = 16'h88F8; idle("R10 idle");
        frame(1, 16'h88F8, 0, 16'd0, 2, 0, "R8 foreign filter type");
        @(negedge clk); cfg_etf_type = ET; idle("R10 idle");

        // R10: back-to-back frames, then matching fields with valid low.
        frame(1, ET, 0, 16'd0, 2, 0, "R10 b2b 1");
        frame(1, 16'h0800, 1, P319, 2, 8, "R10 b2b 2");
        frame(1, 16'h0800, 1, P319, 2, 1, "R10 b2b 3");
        frame(1, 16'h0800, 1, P319, 2, 2, "R10 b2b 4");
        frame(0, 16'h0800, 1, P319, 2, 2, "R10 fields match, valid low");
        idle("R10 idle tail");

        // R11: reserved mode.
        @(negedge clk); cfg_mode = 2'b11; idle("R10 idle");
        frame(1, 16'h0800, 1, P319, 2, 0, "R11 reserved v2");
        frame(1, 16'h0800, 1, P319, 1, 0, "R11 reserved v1");
        idle("R10 idle");
        idle("R10 idle");

        @(negedge clk);
        wait (sb.size() == 0);
        @(posedge clk); #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule